// File: doc/BRIEF.md
# Latched Status Flags with Maskable Interrupt

This block turns short or long status conditions into latched flag bits. Each lane has a receive loss-of-signal condition and a transmit fault condition, and there is one module-wide reset-complete event. A flag stays set until the host reads it. Each flag has a mask bit. A set mask keeps that flag off the interrupt but still lets the flag latch. The interrupt leaves the block as an output-enable for an open-drain pin: 1 pulls the line low, and 0 releases it.

The host side sits behind a serial slave, which lives outside this block. That slave issues byte reads and mask-byte writes. A read returns one flag byte one cycle later and clears the flags it returned. The active-low module-select input gates every access. While it is high, reads are not acknowledged and clear nothing, and mask writes are dropped. A data-not-ready status bit starts at 1 out of reset. The reset-complete event clears it in the same cycle that it raises its own flag.

Byte addresses for reads and mask writes: 0 is the status byte (bit 0 is data-not-ready), 1 holds the receive loss flags, 2 holds the transmit fault flags, and 3 holds the module flags (bit 0 is reset-complete). In bytes 1 and 2, bit i belongs to lane i. `LANES` may be 1 to 8.

Top module: `lane_status_irq`

## Requirements
- R1: After reset all flags and masks are 0, data-not-ready is 1, `intPullLow` is 0 and `rdAck` is 0.
- R2: A high `rxLosIn[i]` sampled on a clock edge sets bit i of byte 1. The bit stays set after the condition goes away, until it is read.
- R3: A high `txFaultIn[i]` sampled on a clock edge sets bit i of byte 2. The bit stays set until it is read.
- R4: Once an unmasked flag is set, `intPullLow` is 1 right after that edge, and it stays 1 while any unmasked flag remains set.
- R5: A selected read of byte 1, 2 or 3 returns the byte on `rdData` with `rdAck` high in the next cycle and clears exactly the flags it returned. `intPullLow` falls to 0 if no other unmasked flag is set.
- R6: If a condition is still high on the edge where its flag is read-cleared, the flag stays set, so a following read returns it again.
- R7: A mask bit of 1, written to byte 1, 2 or 3, keeps its flag from driving `intPullLow` while the flag still latches and reads as 1. Writing the mask back to 0 asserts `intPullLow` on the next cycle.
- R8: `resetDoneIn` clears data-not-ready (bit 0 of byte 0) and sets bit 0 of byte 3 on the same edge. Data-not-ready stays 0 until the next reset.
- R9: While `modSelN` is high, reads produce no `rdAck` and clear no flag, and mask writes change no mask.
- R10: Reading the status byte (0) clears no flag.
- R11: Reading one flag byte leaves the flags of the other bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modSelN | input | 1 | Active-low module select that gates host accesses |
| rxLosIn | input | LANES | Per-lane receive loss-of-signal condition |
| txFaultIn | input | LANES | Per-lane transmit fault condition |
| resetDoneIn | input | 1 | Reset-complete event |
| rdEn | input | 1 | Host byte read request |
| rdAddr | input | 2 | Byte address of the read |
| rdData | output | 8 | Read data, valid while rdAck is 1 |
| rdAck | output | 1 | Read served, one cycle after a selected request |
| mskWrEn | input | 1 | Host mask-byte write request |
| mskAddr | input | 2 | Byte address of the mask write |
| mskData | input | 8 | Mask byte to write, 1 = masked |
| intPullLow | output | 1 | Interrupt output-enable, 1 = drive the line low |

## Verification
Conditions take effect on one clock edge. The flag and `intPullLow` can therefore be seen at the falling edge that follows the edge on which the condition was sampled. A read request driven at a falling edge is captured on the next rising edge, and `rdData`, `rdAck`, the cleared flags and the new `intPullLow` are all sampled at the falling edge after that. A mask write affects `intPullLow` at the falling edge after the write edge. The bench drives every input at a falling edge and samples only at the falling edge one cycle later, which is where each of these results is due.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int NUM_GRP  = 1 << ADDR_W;
  localparam int GRP_STAT = 0;
  localparam int GRP_RX   = 1;
  localparam int GRP_TX   = 2;
  localparam int GRP_MOD  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic                 rdStb;
    logic [ADDR_W-1:0]    rdSel;
    logic [NUM_GRP-1:0]   clrGrp;
    logic [NUM_GRP-1:0]   mskLd;
  } flagCtl_t;
endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modSelN,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              mskWrEn,
  input  logic [ADDR_W-1:0] mskAddr,
  output flagCtl_t          ctl,
  output logic              rdAck
);
  logic              rdOk;
  logic              wrOk;
  logic [NUM_GRP-1:0] clrVec;
  logic [NUM_GRP-1:0] ldVec;

  assign rdOk = rdEn & ~modSelN;
  assign wrOk = mskWrEn & ~modSelN;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    if (g == GRP_STAT) begin : g_stat
      assign clrVec[g] = 1'b0;
      assign ldVec[g]  = 1'b0;
    end else begin : g_flag
      assign clrVec[g] = rdOk && (rdAddr == ADDR_W'(g));
      assign ldVec[g]  = wrOk && (mskAddr == ADDR_W'(g));
    end
  end

  always_comb begin
    ctl.rdStb  = rdOk;
    ctl.rdSel  = rdAddr;
    ctl.clrGrp = clrVec;
    ctl.mskLd  = ldVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdAck <= 1'b0;
    else       rdAck <= rdOk;
  end
endmodule

// File: rtl/flag_dp.sv
module flag_dp
  import flag_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagCtl_t          ctl,
  input  logic [LANES-1:0]  rxLosIn,
  input  logic [LANES-1:0]  txFaultIn,
  input  logic              resetDoneIn,
  input  logic [BYTE_W-1:0] mskData,
  output logic [BYTE_W-1:0] rdData,
  output logic              intPullLow,
  output logic [LANES-1:0]  rxFlag,
  output logic [LANES-1:0]  txFlag,
  output logic [BYTE_W-1:0] rxMaskQ,
  output logic              dataNotReady
);
  logic              modFlag;
  logic [BYTE_W-1:0] txMaskQ;
  logic [BYTE_W-1:0] modMaskQ;
  logic [BYTE_W-1:0] grpByte [NUM_GRP];
  logic [BYTE_W-1:0] pendByte [NUM_GRP];
  logic [NUM_GRP-1:0] grpPend;

  always_comb begin
    grpByte[GRP_STAT] = BYTE_W'(dataNotReady);
    grpByte[GRP_RX]   = BYTE_W'(rxFlag);
    grpByte[GRP_TX]   = BYTE_W'(txFlag);
    grpByte[GRP_MOD]  = BYTE_W'(modFlag);
    pendByte[GRP_STAT] = '0;
    pendByte[GRP_RX]   = grpByte[GRP_RX]  & ~rxMaskQ;
    pendByte[GRP_TX]   = grpByte[GRP_TX]  & ~txMaskQ;
    pendByte[GRP_MOD]  = grpByte[GRP_MOD] & ~modMaskQ;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_pend
    assign grpPend[g] = |pendByte[g];
  end

  assign intPullLow = |grpPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxFlag       <= '0;
      txFlag       <= '0;
      modFlag      <= 1'b0;
      dataNotReady <= 1'b1;
      rxMaskQ      <= '0;
      txMaskQ      <= '0;
      modMaskQ     <= '0;
      rdData       <= '0;
    end else begin
      // set wins over clear so a live condition is never lost
      rxFlag  <= (rxFlag & ~{LANES{ctl.clrGrp[GRP_RX]}}) | rxLosIn;
      txFlag  <= (txFlag & ~{LANES{ctl.clrGrp[GRP_TX]}}) | txFaultIn;
      modFlag <= (modFlag & ~ctl.clrGrp[GRP_MOD]) | resetDoneIn;
      if (resetDoneIn) dataNotReady <= 1'b0;
      if (ctl.mskLd[GRP_RX])  rxMaskQ  <= mskData;
      if (ctl.mskLd[GRP_TX])  txMaskQ  <= mskData;
      if (ctl.mskLd[GRP_MOD]) modMaskQ <= mskData;
      if (ctl.rdStb) rdData <= grpByte[ctl.rdSel];
    end
  end
endmodule

// File: rtl/lane_status_irq.sv
module lane_status_irq
  import flag_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modSelN,
  input  logic [LANES-1:0]  rxLosIn,
  input  logic [LANES-1:0]  txFaultIn,
  input  logic              resetDoneIn,
  input  logic              rdEn,
  input  logic [1:0]        rdAddr,
  output logic [7:0]        rdData,
  output logic              rdAck,
  input  logic              mskWrEn,
  input  logic [1:0]        mskAddr,
  input  logic [7:0]        mskData,
  output logic              intPullLow
);
  flagCtl_t          ctl;
  logic [LANES-1:0]  rxFlag;
  logic [LANES-1:0]  txFlag;
  logic [BYTE_W-1:0] rxMaskQ;
  logic              dataNotReady;

  flag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modSelN(modSelN), .rdEn(rdEn), .rdAddr(rdAddr),
    .mskWrEn(mskWrEn), .mskAddr(mskAddr), .ctl(ctl), .rdAck(rdAck)
  );

  flag_dp #(.LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxLosIn(rxLosIn), .txFaultIn(txFaultIn),
    .resetDoneIn(resetDoneIn), .mskData(mskData), .rdData(rdData),
    .intPullLow(intPullLow), .rxFlag(rxFlag), .txFlag(txFlag),
    .rxMaskQ(rxMaskQ), .dataNotReady(dataNotReady)
  );
endmodule

// File: rtl/lane_status_irq_chk.sv
module lane_status_irq_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             modSelN,
  input logic             rdEn,
  input logic             rdAck,
  input logic             mskWrEn,
  input logic [LANES-1:0] rxLosIn,
  input logic [LANES-1:0] txFaultIn,
  input logic             resetDoneIn,
  input logic             intPullLow,
  input logic [LANES-1:0] rxFlag,
  input logic [LANES-1:0] txFlag,
  input logic [7:0]       rxMaskQ,
  input logic             dataNotReady
);
  AST_LOS_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    (|rxLosIn) |=> (|rxFlag)); // R2
  AST_FAULT_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    (|txFaultIn) |=> (|txFlag)); // R3
  AST_UNMASKED_RAISES_INT: assert property (@(posedge clk) disable iff (!rstN)
    ((|rxLosIn) && (rxMaskQ[LANES-1:0] == '0) && !mskWrEn) |=> intPullLow); // R4
  AST_LIVE_COND_SURVIVES: assert property (@(posedge clk) disable iff (!rstN)
    (rxLosIn[0] && rdEn) |=> rxFlag[0]); // R6
  AST_DONE_CLEARS_DNR: assert property (@(posedge clk) disable iff (!rstN)
    resetDoneIn |=> !dataNotReady); // R8
  AST_DNR_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !dataNotReady |=> !dataNotReady); // R8
  AST_NO_ACK_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (modSelN || !rdEn) |=> !rdAck); // R9
  AST_ACK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    rdAck |-> $past(rdEn && !modSelN)); // R9
endmodule

bind lane_status_irq lane_status_irq_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rstN(rstN), .modSelN(modSelN), .rdEn(rdEn), .rdAck(rdAck),
  .mskWrEn(mskWrEn), .rxLosIn(rxLosIn), .txFaultIn(txFaultIn),
  .resetDoneIn(resetDoneIn), .intPullLow(intPullLow), .rxFlag(rxFlag),
  .txFlag(txFlag), .rxMaskQ(rxMaskQ), .dataNotReady(dataNotReady)
);

// File: tb/lane_status_irq_test.sv
`timescale 1ns/1ps
module lane_status_irq_test;
  localparam int LANES = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             modSelN = 1'b0;
  logic [LANES-1:0] rxLosIn = '0;
  logic [LANES-1:0] txFaultIn = '0;
  logic             resetDoneIn = 1'b0;
  logic             rdEn = 1'b0;
  logic [1:0]       rdAddr = '0;
  logic [7:0]       rdData;
  logic             rdAck;
  logic             mskWrEn = 1'b0;
  logic [1:0]       mskAddr = '0;
  logic [7:0]       mskData = '0;
  logic             intPullLow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lane_status_irq #(.LANES(LANES)) uut (
    .clk(clk), .rstN(rstN), .modSelN(modSelN), .rxLosIn(rxLosIn),
    .txFaultIn(txFaultIn), .resetDoneIn(resetDoneIn), .rdEn(rdEn),
    .rdAddr(rdAddr), .rdData(rdData), .rdAck(rdAck), .mskWrEn(mskWrEn),
    .mskAddr(mskAddr), .mskData(mskData), .intPullLow(intPullLow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one-cycle read; returns data and ack sampled one cycle later
  task automatic hostRead(input logic [1:0] a, output logic [7:0] d, output logic ack);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    d = rdData; ack = rdAck;
    rdEn = 1'b0;
  endtask

  task automatic maskWrite(input logic [1:0] a, input logic [7:0] v);
    mskWrEn = 1'b1; mskAddr = a; mskData = v;
    @(negedge clk);
    mskWrEn = 1'b0;
  endtask

  task automatic pulseRx(input logic [LANES-1:0] v);
    rxLosIn = v; @(negedge clk); rxLosIn = '0;
  endtask

  task automatic pulseTx(input logic [LANES-1:0] v);
    txFaultIn = v; @(negedge clk); txFaultIn = '0;
  endtask

  task automatic testReset();
    logic [7:0] d; logic a;
    check("R1 int", intPullLow, 0);
    check("R1 ack", rdAck, 0);
    hostRead(2'd0, d, a);
    check("R1 status dnr", d, 8'h01);
    check("R1 ack", a, 1);
    hostRead(2'd1, d, a); check("R1 rx flags", d, 0);
    hostRead(2'd2, d, a); check("R1 tx flags", d, 0);
    hostRead(2'd3, d, a); check("R1 mod flags", d, 0);
  endtask

  task automatic testRxLatch();
    logic [7:0] d; logic a;
    pulseRx(4'b0100);
    check("R4 int after rx", intPullLow, 1);
    @(negedge clk);
    check("R2 int held", intPullLow, 1);
    hostRead(2'd1, d, a);
    check("R2 rx byte", d, 8'h04);
    check("R5 ack", a, 1);
    check("R5 int released", intPullLow, 0);
    hostRead(2'd1, d, a);
    check("R5 cleared", d, 8'h00);
  endtask

  task automatic testTxLatch();
    logic [7:0] d; logic a;
    pulseTx(4'b1001);
    check("R4 int after tx", intPullLow, 1);
    hostRead(2'd2, d, a);
    check("R3 tx byte", d, 8'h09);
    check("R5 int released", intPullLow, 0);
  endtask

  task automatic testLiveCond();
    logic [7:0] d; logic a;
    rxLosIn = 4'b0010;
    @(negedge clk);
    hostRead(2'd1, d, a);
    check("R6 first read", d, 8'h02);
    check("R6 int kept", intPullLow, 1);
    hostRead(2'd1, d, a);
    check("R6 second read", d, 8'h02);
    rxLosIn = '0;
    hostRead(2'd1, d, a);
    check("R6 last latched", d, 8'h02);
    check("R6 int released", intPullLow, 0);
    hostRead(2'd1, d, a);
    check("R6 finally clear", d, 8'h00);
  endtask

  task automatic testMask();
    logic [7:0] d; logic a;
    maskWrite(2'd1, 8'h0F);
    pulseRx(4'b0001);
    check("R7 masked no int", intPullLow, 0);
    @(negedge clk);
    check("R7 masked still no int", intPullLow, 0);
    maskWrite(2'd1, 8'h00);
    check("R7 unmask raises int", intPullLow, 1);
    hostRead(2'd1, d, a);
    check("R7 flag latched under mask", d, 8'h01);
    check("R7 int released", intPullLow, 0);
  endtask

  task automatic testResetDone();
    logic [7:0] d; logic a;
    resetDoneIn = 1'b1; @(negedge clk); resetDoneIn = 1'b0;
    check("R8 int", intPullLow, 1);
    hostRead(2'd0, d, a);
    check("R8 dnr cleared", d, 8'h00);
    check("R10 status read keeps int", intPullLow, 1);
    hostRead(2'd3, d, a);
    check("R8 done flag", d, 8'h01);
    check("R8 int released", intPullLow, 0);
    hostRead(2'd0, d, a);
    check("R8 dnr stays clear", d, 8'h00);
  endtask

  task automatic testDeselect();
    logic [7:0] d; logic a;
    pulseTx(4'b0010);
    modSelN = 1'b1;
    hostRead(2'd2, d, a);
    check("R9 no ack", a, 0);
    check("R9 int kept", intPullLow, 1);
    maskWrite(2'd2, 8'hFF);
    check("R9 mask ignored", intPullLow, 1);
    modSelN = 1'b0;
    hostRead(2'd2, d, a);
    check("R9 flag kept", d, 8'h02);
    check("R9 ack when selected", a, 1);
    check("R9 int released", intPullLow, 0);
  endtask

  task automatic testGroups();
    logic [7:0] d; logic a;
    rxLosIn = 4'b1000; txFaultIn = 4'b0100;
    @(negedge clk);
    rxLosIn = '0; txFaultIn = '0;
    hostRead(2'd1, d, a);
    check("R11 rx byte", d, 8'h08);
    check("R11 tx keeps int", intPullLow, 1);
    hostRead(2'd2, d, a);
    check("R11 tx byte intact", d, 8'h04);
    check("R11 int released", intPullLow, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRxLatch();
    testTxLatch();
    testLiveCond();
    testMask();
    testResetDone();
    testDeselect();
    testGroups();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule